// File: doc/BRIEF.md
# Gated Serial Peripheral Slave

This block is the receive/transmit engine of a serial peripheral slave. An external master supplies the serial clock. Each clock period moves one bit in each direction at once, most significant bit first. The serial clock, the data input and the select input are brought into the system clock domain through two-flop synchronizers. The synchronized clock is then watched for edges. Clock polarity and phase pick which edge captures incoming data and which edge launches the next outgoing bit.

The block has two wiring modes. In 3-pin mode the select input is ignored, and the slave runs whenever the master toggles the clock. In 4-pin mode the slave works only while the active-low select is low. Raising select freezes a byte in flight at the bit where it stands and turns off the data output driver. Clock edges seen while deselected are discarded. When select returns, the byte carries on from the same bit.

Software loads the outgoing byte through a parallel port with a write strobe. It reads each incoming byte from a receive register that is announced by a one-cycle valid pulse. A synchronous software reset aborts any transfer at once.

Top module: `spi_slave_gated`

## Requirements
- R1: Polarity `cpol_i` sets the idle clock level. With `cpha_i`=0 data is captured on the edge leaving idle; with `cpha_i`=1 it is captured on the edge returning to idle. The outgoing bit changes on the other edge.
- R2: Reception and transmission run on the same clock edges, MSB first. The byte on `sdi_i` is received while the byte held for transmit appears on `sdo_o`.
- R3: In 4-pin mode (`four_pin_i`=1) with `sel_ni` high, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R4: While deselected in 4-pin mode, clock edges are ignored. The bit position and the partially received data are kept, `busy_o` stays as it was, and the byte resumes from the same bit once `sel_ni` is low again.
- R5: In 3-pin mode (`four_pin_i`=0) the level of `sel_ni` has no effect, and `sdo_oe_o` is 1 whenever software reset is low.
- R6: On the eighth capture, `rx_data_o` takes the received byte and `rx_valid_o` is 1 for exactly one system clock cycle.
- R7: `busy_o` is 1 while between one and seven bits of the current byte have been captured, and 0 otherwise.
- R8: While `sw_rst_i` is 1, the bit position is cleared, `busy_o` becomes 0 on the next cycle, and `sdo_oe_o` is 0. The next byte starts again at bit 7, carrying the last byte written.
- R9: A byte written while `busy_o` is 0 is sent in the next byte. A byte written while `busy_o` is 1 is held and does not alter the byte in flight. It is sent in the following byte.
- R10: With `cpha_i`=0, bit 7 of the transmit byte is on `sdo_o` once the slave is selected and before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_rst_i | input | 1 | Synchronous software reset, aborts transfer |
| four_pin_i | input | 1 | 1 = select gates operation, 0 = select ignored |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0 = capture on leading edge, 1 = on trailing edge |
| sclk_i | input | 1 | Serial clock from master |
| sel_ni | input | 1 | Slave select, active low |
| sdi_i | input | 1 | Serial data from master |
| sdo_o | output | 1 | Serial data to master |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| tx_data_i | input | DATA_W | Byte to transmit |
| tx_we_i | input | 1 | Write strobe for tx_data_i |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle pulse when rx_data_o updates |
| busy_o | output | 1 | Byte in progress |

## Verification
Two functions can act in the same cycle: the master's clock edges and the select gate. The bench deselects the slave right after every possible capture count, in each of the four clock modes. While deselected it toggles the clock through two full periods and changes the data input. These frozen-window edges are judged at the ports: the output enable must drop, `busy_o` must hold, no valid pulse may appear, and after reselection both the received byte and the transmitted byte must match the values computed for an uninterrupted transfer. A second overlap is a transmit write landing in the middle of a byte. It is judged by the byte seen on `sdo_o` in that transfer and in the next one.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef struct packed {
    logic cap;
    logic launch;
  } spi_evt_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= RST_VAL;
    else         pipe_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= RST_VAL;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
  import spi_slv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_i,
  input  logic     cpol_i,
  input  logic     cpha_i,
  input  logic     qual_i,
  output spi_evt_t evt_o
);
  logic prev_q;
  logic rise, fall, lead, trail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sclk_i;
  end

  assign rise  = sclk_i & ~prev_q;
  assign fall  = ~sclk_i & prev_q;
  assign lead  = cpol_i ? fall : rise;
  assign trail = cpol_i ? rise : fall;

  // edges outside the active window are dropped, not deferred
  assign evt_o.cap    = qual_i & (cpha_i ? trail : lead);
  assign evt_o.launch = qual_i & (cpha_i ? lead : trail);
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  spi_evt_t          evt_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_we_i,
  output logic              sdo_bit_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, out_idx_q, bit_sel;
  logic [DATA_W-1:0] rx_sr_q, rx_data_q, tx_buf_q, tx_cur_q;
  logic              valid_q;
  logic              wrap;

  assign wrap = evt_i.cap && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      out_idx_q <= '0;
      rx_sr_q   <= '0;
      rx_data_q <= '0;
      valid_q   <= 1'b0;
    end else if (clr_i) begin
      cnt_q     <= '0;
      out_idx_q <= '0;
      rx_sr_q   <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (evt_i.cap) begin
        rx_sr_q <= {rx_sr_q[DATA_W-2:0], sdi_i};
        if (wrap) begin
          cnt_q     <= '0;
          rx_data_q <= {rx_sr_q[DATA_W-2:0], sdi_i};
          valid_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (evt_i.launch) out_idx_q <= cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q <= '0;
      tx_cur_q <= '0;
    end else begin
      if (tx_we_i) tx_buf_q <= tx_data_i;
      if (clr_i)
        tx_cur_q <= tx_we_i ? tx_data_i : tx_buf_q;
      else if (wrap)
        tx_cur_q <= tx_we_i ? tx_data_i : tx_buf_q;
      else if (tx_we_i && cnt_q == '0)
        tx_cur_q <= tx_data_i;
    end
  end

  assign bit_sel    = LAST - out_idx_q;
  assign sdo_bit_o  = tx_cur_q[bit_sel];
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = valid_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/spi_slave_gated.sv
module spi_slave_gated
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_rst_i,
  input  logic              four_pin_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              sclk_i,
  input  logic              sel_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_we_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W  = $clog2(DATA_W);
  localparam int unsigned WARM   = SYNC_STAGES + 1;
  localparam int unsigned WARM_W = $clog2(WARM + 1);

  logic [2:0]       pins_s;
  logic             sclk_s, sdi_s, sel_s;
  logic [WARM_W-1:0] warm_q;
  logic             warm_done, link_active;
  logic [CNT_W-1:0] bit_cnt;
  logic             sdo_bit;
  spi_evt_t         evt;

  spi_slv_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sel_ni, sdi_i, sclk_i}),
    .q_o   (pins_s)
  );

  assign {sel_s, sdi_s, sclk_s} = pins_s;

  // hold edge detection off until the sync pipe carries real pin values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                warm_q <= '0;
    else if (sw_rst_i)          warm_q <= '0;
    else if (!warm_done)        warm_q <= warm_q + 1'b1;
  end

  assign warm_done   = (warm_q == WARM_W'(WARM));
  assign link_active = warm_done && !sw_rst_i && (!four_pin_i || !sel_s);

  spi_slv_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sclk_i(sclk_s),
    .cpol_i(cpol_i),
    .cpha_i(cpha_i),
    .qual_i(link_active),
    .evt_o (evt)
  );

  spi_slv_shift #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sw_rst_i),
    .evt_i     (evt),
    .sdi_i     (sdi_s),
    .tx_data_i (tx_data_i),
    .tx_we_i   (tx_we_i),
    .sdo_bit_o (sdo_bit),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o),
    .cnt_o     (bit_cnt)
  );

  assign sdo_oe_o = link_active;
  assign sdo_o    = link_active & sdo_bit;
  assign busy_o   = (bit_cnt != '0);
endmodule

// File: rtl/spi_slave_gated_chk.sv
module spi_slave_gated_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sw_rst_i,
  input logic             link_active,
  input logic             cap_evt,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sdo_oe_o,
  input logic             busy_o,
  input logic             rx_valid_o
);
  AST_OE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_active |-> !sdo_oe_o); // R3

  AST_FROZEN_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni || sw_rst_i)
    !link_active |=> $stable(bit_cnt)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R6

  AST_VALID_FROM_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(cap_evt)); // R6

  AST_BUSY_AFTER_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni || sw_rst_i)
    cap_evt |=> (busy_o || rx_valid_o)); // R7

  AST_SWRST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> !busy_o); // R8

  AST_SWRST_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |-> !sdo_oe_o); // R8
endmodule

bind spi_slave_gated spi_slave_gated_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sw_rst_i   (sw_rst_i),
  .link_active(link_active),
  .cap_evt    (evt.cap),
  .bit_cnt    (bit_cnt),
  .sdo_oe_o   (sdo_oe_o),
  .busy_o     (busy_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/spi_slave_gated_tb.sv
module spi_slave_gated_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 1'b1;
  logic four_pin = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic sclk = 1'b0, sel_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, rx_valid, busy;
  logic [DW-1:0] tx_data = '0, rx_data;
  logic tx_we = 1'b0;

  int n_chk = 0, n_fail = 0, vcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slave_gated #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .four_pin_i(four_pin),
    .cpol_i(cpol), .cpha_i(cpha), .sclk_i(sclk), .sel_ni(sel_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .tx_data_i(tx_data), .tx_we_i(tx_we),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .busy_o(busy)
  );

  always @(posedge clk) if (rx_valid) vcnt <= vcnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic fp, input logic pol, input logic pha);
    sw_rst = 1'b1;
    four_pin = fp; cpol = pol; cpha = pha; sclk = pol; sel_n = 1'b1;
    waitn(6);
    sw_rst = 1'b0;
    waitn(6);
  endtask

  task automatic write_tx(input logic [DW-1:0] b);
    tx_data = b; tx_we = 1'b1;
    waitn(1);
    tx_we = 1'b0;
    waitn(1);
  endtask

  // deselect right after `k` captures, toggle clock while frozen, reselect
  task automatic pause_window(input int k);
    int v0;
    v0 = vcnt;
    sel_n = 1'b1;
    waitn(6);
    chk(sdo_oe == 1'b0 && sdo == 1'b0, "R3 oe released", sdo_oe, 0);
    chk(busy == 1'b1, "R4 busy held while frozen", busy, 1);
    for (int t = 0; t < 2; t++) begin
      sclk = ~cpol; sdi = ~sdi; waitn(HALF);
      sclk = cpol;  sdi = ~sdi; waitn(HALF);
    end
    chk(busy == 1'b1 && vcnt == v0, "R4 edges ignored", vcnt - v0, 0);
    sel_n = 1'b0;
    waitn(6);
  endtask

  task automatic xfer(input logic [DW-1:0] mo, input int nbits, input int pause_at,
                      input int wr_at, input logic [DW-1:0] wr_val,
                      output logic [DW-1:0] mi, output logic first_bit);
    mi = '0;
    first_bit = 1'b0;
    if (four_pin) begin
      sel_n = 1'b0;
      waitn(HALF);
    end
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        sdi = mo[DW-1-i];
        waitn(HALF);
        if (i == 0) first_bit = sdo;
        mi[DW-1-i] = sdo;
        sclk = ~cpol;
        waitn(HALF);
        sclk = cpol;
        waitn(HALF);
      end else begin
        sclk = ~cpol;
        sdi = mo[DW-1-i];
        waitn(HALF);
        mi[DW-1-i] = sdo;
        sclk = cpol;
        waitn(HALF);
      end
      if (pause_at == i + 1 && four_pin) pause_window(i + 1);
      if (wr_at == i + 1) begin
        tx_data = wr_val; tx_we = 1'b1;
        waitn(1);
        tx_we = 1'b0;
      end
    end
    waitn(6);
    if (four_pin) begin
      sel_n = 1'b1;
      waitn(6);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] mo, tx, mi, t2;
    logic fb;
    int v0;
    waitn(3);
    // reset state
    chk(busy == 1'b0 && rx_valid == 1'b0 && rx_data == '0, "R7 reset idle", busy, 0);
    rst_n = 1'b1;
    waitn(2);
    chk(sdo_oe == 1'b0, "R8 oe low under sw reset", sdo_oe, 0);

    // sweep: both pin modes, all four clock modes, eight bytes each
    for (int fp = 0; fp < 2; fp++) begin
      for (int md = 0; md < 4; md++) begin
        setup(fp[0], md[1], md[0]);
        for (int k = 0; k < 8; k++) begin
          mo = DW'(k * 37 + md * 11 + fp * 5) ^ 8'hA5;
          tx = DW'(k * 73 + 19 + md * 3 + fp);
          if (!fp[0]) sel_n = k[0]; // R5: select level is irrelevant in 3-pin mode
          write_tx(tx);
          if (!fp[0]) chk(sdo_oe == 1'b1, "R5 oe in 3-pin mode", sdo_oe, 1);
          v0 = vcnt;
          xfer(mo, DW, 0, 0, '0, mi, fb);
          chk(rx_data == mo, "R1 R2 received byte", rx_data, mo);
          chk(mi == tx, "R1 R2 transmitted byte", mi, tx);
          chk(vcnt == v0 + 1, "R6 single valid pulse", vcnt - v0, 1);
          chk(busy == 1'b0, "R7 idle after byte", busy, 0);
          if (!md[0]) chk(fb == tx[DW-1], "R10 bit 7 before first edge", fb, tx[DW-1]);
        end
      end
    end

    // frozen transfer: every pause point in every clock mode
    for (int md = 0; md < 4; md++) begin
      setup(1'b1, md[1], md[0]);
      for (int k = 1; k < DW; k++) begin
        mo = DW'(k * 29 + md) ^ 8'h3C;
        tx = DW'(k * 51 + md * 7) ^ 8'hC3;
        write_tx(tx);
        v0 = vcnt;
        xfer(mo, DW, k, 0, '0, mi, fb);
        chk(rx_data == mo, "R4 rx resumes same bit", rx_data, mo);
        chk(mi == tx, "R4 tx resumes same bit", mi, tx);
        chk(vcnt == v0 + 1, "R4 R6 one pulse across pause", vcnt - v0, 1);
      end
    end

    // mid-byte transmit write is deferred
    setup(1'b0, 1'b0, 1'b0);
    tx = 8'h5A; t2 = 8'hE1;
    write_tx(tx);
    xfer(8'h11, DW, 0, 3, t2, mi, fb);
    chk(mi == tx, "R9 byte in flight unchanged", mi, tx);
    xfer(8'h22, DW, 0, 0, '0, mi, fb);
    chk(mi == t2, "R9 held byte sent next", mi, t2);
    chk(rx_data == 8'h22, "R2 byte after deferred write", rx_data, 8'h22);

    // software reset mid-byte
    for (int md = 0; md < 4; md++) begin
      setup(1'b1, md[1], md[0]);
      write_tx(8'h96);
      v0 = vcnt;
      xfer(8'hFF, 5, 0, 0, '0, mi, fb);
      chk(busy == 1'b1, "R7 busy mid-byte", busy, 1);
      sw_rst = 1'b1;
      sclk = cpol;
      waitn(2);
      chk(busy == 1'b0 && sdo_oe == 1'b0, "R8 abort clears", busy, 0);
      waitn(4);
      sw_rst = 1'b0;
      waitn(6);
      chk(vcnt == v0, "R8 no pulse from aborted byte", vcnt - v0, 0);
      xfer(8'h4B, DW, 0, 0, '0, mi, fb);
      chk(rx_data == 8'h4B, "R8 clean restart rx", rx_data, 8'h4B);
      chk(mi == 8'h96, "R8 restart resends last byte", mi, 8'h96);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule